// File: doc/BRIEF.md
# Indirect Target Provider Selector

This block makes the final indirect-jump target decision for one prediction block. Five tagged tables, ordered from shortest to longest history, each return a hit flag, a 2-bit confidence counter, a useful bit and a 41-bit target for the looked-up entry. An upstream target buffer also supplies a fallback target. The block ranks the hits. The longest-history hit is the provider and the next-longest hit is the alternate. The confidence counters then decide which of three sources drives the result: the provider (SRC_PROVIDER), the alternate (SRC_ALTERNATE) or the fallback (SRC_FALLBACK). The counters play no part in any taken/not-taken direction.

The decision is combinational in the stage that holds the raw table responses. It is captured into the final stage on an edge where the stage-advance input `s2_fire` is high, and the registers keep their value otherwise. Together with the target, the block captures a 101-bit metadata word for later training. The word records the provider, the alternate, their counters and targets, and a candidate table for allocating a new entry. Only one indirect jump per block is handled, so each lookup yields exactly one target.

Top module: `itgt_select`

## Requirements
- R1: While `rst_n` is low, `pred_target` and `pred_meta` are all zero.
- R2: When no table hits, the captured target equals `fallback_target`.
- R3: The provider is the hitting table with the highest number (T5 longest). When its counter is not 00, the captured target is the provider's target.
- R4: When the provider's counter is 00 and a shorter table also hits, the captured target is the target of the highest-numbered of those shorter hits (the alternate).
- R5: When the provider's counter is 00 and no shorter table hits, the captured target is `fallback_target`.
- R6: On an edge where `s2_fire` is low, `pred_target` and `pred_meta` keep their values whatever the other inputs do.
- R7: The metadata layout is as follows. Bit 100 is provider-valid and [99:97] is the provider table number n (Tn; 0 when none). Bit 96 is alternate-valid and [95:93] is the alternate number. Bit 91 is the provider useful bit. [90:89] is the provider counter and [88:87] is the alternate counter. [81:41] is the provider target and [40:0] is the alternate target. The provider number is always larger than the alternate number.
- R8: When no alternate exists, bit 96, [95:93], [88:87] and [40:0] are zero. When no provider exists, bit 100, [99:97], bit 91, [90:89] and [81:41] are zero.
- R9: Bit 92 is set exactly when an alternate exists and its counter is 00. Bit 82 is 1 in every captured word.
- R10: The allocate field holds the lowest-numbered table above the provider whose useful bit is 0. Every table counts as above when there is no provider. Bit 86 is its valid flag and [85:83] is its number. Both are 0 when no such table exists.
- R11: A lookup presented with `s2_fire` high appears on the outputs right after that clock edge and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s2_fire | input | 1 | Stage advance: capture the selection on this edge |
| tbl_hit | input | 5 | Hit flag per table, bit n-1 for Tn |
| tbl_ctr | input | 10 | Confidence counters, Tn at [2n-1:2n-2] |
| tbl_useful | input | 5 | Useful bit per table, bit n-1 for Tn |
| tbl_target | input | 205 | Targets, Tn at [41n-1:41n-41] |
| fallback_target | input | 41 | Target from the upstream target buffer |
| pred_target | output | 41 | Selected target, final stage |
| pred_meta | output | 101 | Training metadata word, final stage |

## Verification
The embedded assertions check the cycle-to-cycle rules on every clock. These are the hold on an idle stage, the fallback target when nothing hits, the agreement between the output target and the provider or alternate fields of the metadata, the provider ranking above the alternate, the zeroed alternate fields and the constant taken bit. The assertions cannot show that the right table was ranked as provider or alternate from a hit pattern. Nor can they show the allocate choice, the exact useful bit and counter copied, or the one-edge latency. The bench's vector table and directed cases cover these by comparing against values derived from the requirements.

// File: rtl/itgt_pkg.sv
package itgt_pkg;
    localparam int TGT_W = 41;
    localparam int CTR_W = 2;
    localparam int NUM_TABLES = 5;

    typedef enum logic [1:0] {
        SRC_FALLBACK  = 2'd0,
        SRC_PROVIDER  = 2'd1,
        SRC_ALTERNATE = 2'd2
    } src_e;
endpackage

// File: rtl/itgt_hit_rank.sv
module itgt_hit_rank #(
    parameter int N     = 5,
    parameter int NUM_W = 3
) (
    input  logic [N-1:0]     hit,
    output logic             prov_valid,
    output logic [NUM_W-1:0] prov_num,
    output logic             alt_valid,
    output logic [NUM_W-1:0] alt_num
);
    // Walk from shortest to longest history; each new hit demotes the
    // previous provider to alternate.
    always_comb begin
        prov_valid = 1'b0;
        prov_num   = '0;
        alt_valid  = 1'b0;
        alt_num    = '0;
        for (int i = 0; i < N; i++) begin
            if (hit[i]) begin
                alt_valid  = prov_valid;
                alt_num    = prov_num;
                prov_valid = 1'b1;
                prov_num   = NUM_W'(i + 1);
            end
        end
    end
endmodule

// File: rtl/itgt_alloc_pick.sv
module itgt_alloc_pick #(
    parameter int N     = 5,
    parameter int NUM_W = 3
) (
    input  logic [N-1:0]     useful,
    input  logic             prov_valid,
    input  logic [NUM_W-1:0] prov_num,
    output logic             alloc_valid,
    output logic [NUM_W-1:0] alloc_num
);
    // Scan downward so the lowest eligible table is the last one written.
    always_comb begin
        alloc_valid = 1'b0;
        alloc_num   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!useful[i] && (!prov_valid || (i + 1) > int'(prov_num))) begin
                alloc_valid = 1'b1;
                alloc_num   = NUM_W'(i + 1);
            end
        end
    end
endmodule

// File: rtl/itgt_select.sv
module itgt_select
    import itgt_pkg::*;
#(
    parameter int N      = NUM_TABLES,
    parameter int TW     = TGT_W,
    parameter int CW     = CTR_W,
    localparam int NUM_W = $clog2(N + 1),
    localparam int P_ALT_TGT   = 0,
    localparam int P_PROV_TGT  = TW,
    localparam int P_TAKEN     = 2 * TW,
    localparam int P_ALLOC_NUM = P_TAKEN + 1,
    localparam int P_ALLOC_V   = P_ALLOC_NUM + NUM_W,
    localparam int P_ALT_CTR   = P_ALLOC_V + 1,
    localparam int P_PROV_CTR  = P_ALT_CTR + CW,
    localparam int P_PROV_U    = P_PROV_CTR + CW,
    localparam int P_ALT_WEAK  = P_PROV_U + 1,
    localparam int P_ALT_NUM   = P_ALT_WEAK + 1,
    localparam int P_ALT_V     = P_ALT_NUM + NUM_W,
    localparam int P_PROV_NUM  = P_ALT_V + 1,
    localparam int P_PROV_V    = P_PROV_NUM + NUM_W,
    localparam int META_W      = P_PROV_V + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s2_fire,
    input  logic [N-1:0]      tbl_hit,
    input  logic [N*CW-1:0]   tbl_ctr,
    input  logic [N-1:0]      tbl_useful,
    input  logic [N*TW-1:0]   tbl_target,
    input  logic [TW-1:0]     fallback_target,
    output logic [TW-1:0]     pred_target,
    output logic [META_W-1:0] pred_meta
);
    logic             prov_valid, alt_valid, alloc_valid;
    logic [NUM_W-1:0] prov_num, alt_num, alloc_num;
    logic [CW-1:0]    prov_ctr, alt_ctr;
    logic             prov_u;
    logic [TW-1:0]    prov_tgt, alt_tgt;
    logic             alt_weak;
    src_e             src;
    logic [TW-1:0]    sel_target;
    logic [META_W-1:0] sel_meta;

    itgt_hit_rank #(.N(N), .NUM_W(NUM_W)) u_rank (
        .hit        (tbl_hit),
        .prov_valid (prov_valid),
        .prov_num   (prov_num),
        .alt_valid  (alt_valid),
        .alt_num    (alt_num)
    );

    itgt_alloc_pick #(.N(N), .NUM_W(NUM_W)) u_alloc (
        .useful      (tbl_useful),
        .prov_valid  (prov_valid),
        .prov_num    (prov_num),
        .alloc_valid (alloc_valid),
        .alloc_num   (alloc_num)
    );

    // Field extraction: a table number of 0 matches nothing, leaving zeros.
    always_comb begin
        prov_ctr = '0;
        alt_ctr  = '0;
        prov_u   = 1'b0;
        prov_tgt = '0;
        alt_tgt  = '0;
        for (int i = 0; i < N; i++) begin
            if (int'(prov_num) == i + 1) begin
                prov_ctr = tbl_ctr[i*CW +: CW];
                prov_u   = tbl_useful[i];
                prov_tgt = tbl_target[i*TW +: TW];
            end
            if (int'(alt_num) == i + 1) begin
                alt_ctr = tbl_ctr[i*CW +: CW];
                alt_tgt = tbl_target[i*TW +: TW];
            end
        end
    end

    assign alt_weak = alt_valid && (alt_ctr == '0);

    // Source decision
    always_comb begin
        if (!prov_valid)
            src = SRC_FALLBACK;
        else if (prov_ctr != '0)
            src = SRC_PROVIDER;
        else if (alt_valid)
            src = SRC_ALTERNATE;
        else
            src = SRC_FALLBACK;
    end

    always_comb begin
        unique case (src)
            SRC_PROVIDER:  sel_target = prov_tgt;
            SRC_ALTERNATE: sel_target = alt_tgt;
            default:       sel_target = fallback_target;
        endcase
    end

    assign sel_meta = {prov_valid, prov_num, alt_valid, alt_num, alt_weak,
                       prov_u, prov_ctr, alt_ctr, alloc_valid, alloc_num,
                       1'b1, prov_tgt, alt_tgt};

    // Final-stage register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_target <= '0;
            pred_meta   <= '0;
        end else if (s2_fire) begin
            pred_target <= sel_target;
            pred_meta   <= sel_meta;
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !s2_fire |=> $stable(pred_target) && $stable(pred_meta)); // R6
    AST_NO_HIT_FALLBACK: assert property (@(posedge clk) disable iff (!rst_n)
        (s2_fire && !(|tbl_hit)) |=> pred_target == $past(fallback_target)); // R2
    AST_STRONG_PROVIDER: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_meta[P_PROV_V] && pred_meta[P_PROV_CTR +: CW] != '0)
        |-> pred_target == pred_meta[P_PROV_TGT +: TW]); // R3
    AST_WEAK_TO_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_meta[P_PROV_V] && pred_meta[P_PROV_CTR +: CW] == '0 && pred_meta[P_ALT_V])
        |-> pred_target == pred_meta[P_ALT_TGT +: TW]); // R4
    AST_PROVIDER_ABOVE_ALT: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_meta[P_PROV_V] && pred_meta[P_ALT_V])
        |-> pred_meta[P_PROV_NUM +: NUM_W] > pred_meta[P_ALT_NUM +: NUM_W]); // R7
    AST_ALT_FIELDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_meta[P_ALT_V] |-> (pred_meta[P_ALT_NUM +: NUM_W] == '0
        && pred_meta[P_ALT_CTR +: CW] == '0 && pred_meta[P_ALT_TGT +: TW] == '0
        && !pred_meta[P_ALT_WEAK])); // R8
    AST_TAKEN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        s2_fire |=> pred_meta[P_TAKEN]); // R9
endmodule

// File: tb/itgt_select_tb.sv
`timescale 1ns/1ps
module itgt_select_tb;
    localparam int N = 5;
    localparam int TW = 41;
    localparam int NV = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          s2_fire = 1'b0;
    logic [4:0]    tbl_hit = '0;
    logic [9:0]    tbl_ctr = '0;
    logic [4:0]    tbl_useful = '0;
    logic [N*TW-1:0] tbl_target;
    logic [40:0]   fallback_target = 41'h0AB_CDEF_0123;
    logic [40:0]   pred_target;
    logic [100:0]  pred_meta;

    int checks = 0;
    int fails = 0;

    itgt_select u_dut (
        .clk(clk), .rst_n(rst_n), .s2_fire(s2_fire), .tbl_hit(tbl_hit),
        .tbl_ctr(tbl_ctr), .tbl_useful(tbl_useful), .tbl_target(tbl_target),
        .fallback_target(fallback_target), .pred_target(pred_target),
        .pred_meta(pred_meta)
    );

    always #4 clk = ~clk;

    typedef struct packed {
        logic [4:0] hit;
        logic [9:0] ctr;
        logic [4:0] useful;
        logic [2:0] sel;    // 0 = fallback, n = Tn
        logic [2:0] prov;
        logic [2:0] alt;
        logic [2:0] alloc;
    } vec_t;

    localparam vec_t [0:NV-1] VECS = '{
        '{5'b00000, 10'b0000000000, 5'b00000, 3'd0, 3'd0, 3'd0, 3'd1},
        '{5'b00100, 10'b0000010000, 5'b00000, 3'd3, 3'd3, 3'd0, 3'd4},
        '{5'b10010, 10'b0000001000, 5'b00000, 3'd2, 3'd5, 3'd2, 3'd0},
        '{5'b01000, 10'b0000000000, 5'b10000, 3'd0, 3'd4, 3'd0, 3'd0},
        '{5'b11111, 10'b1111111111, 5'b00000, 3'd5, 3'd5, 3'd4, 3'd0},
        '{5'b00011, 10'b0000000000, 5'b11100, 3'd1, 3'd2, 3'd1, 3'd0},
        '{5'b00001, 10'b0000000011, 5'b01010, 3'd1, 3'd1, 3'd0, 3'd3},
        '{5'b10101, 10'b0100000000, 5'b00000, 3'd5, 3'd5, 3'd3, 3'd0}
    };

    function automatic logic [40:0] tgt(int n);
        if (n == 0) return 41'h0;
        return 41'h155_0000_0000 | 41'(n * 32'h0011_1111);
    endfunction

    function automatic logic [1:0] ctr_of(logic [9:0] c, int n);
        if (n == 0) return 2'b00;
        return c[(n-1)*2 +: 2];
    endfunction

    function automatic logic [100:0] exp_meta(vec_t v);
        logic [1:0] ac;
        logic pu;
        ac = ctr_of(v.ctr, int'(v.alt));
        pu = (v.prov != 0) ? v.useful[v.prov - 1] : 1'b0;
        return {(v.prov != 0), v.prov, (v.alt != 0), v.alt,
                ((v.alt != 0) && ac == 2'b00), pu, ctr_of(v.ctr, int'(v.prov)), ac,
                (v.alloc != 0), v.alloc, 1'b1, tgt(int'(v.prov)), tgt(int'(v.alt))};
    endfunction

    task automatic check(string tag, logic [127:0] got, logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic drive(vec_t v, logic fire);
        tbl_hit    = v.hit;
        tbl_ctr    = v.ctr;
        tbl_useful = v.useful;
        s2_fire    = fire;
    endtask

    initial begin
        for (int i = 0; i < N; i++) tbl_target[i*TW +: TW] = tgt(i + 1);
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [40:0] held_t;
        logic [100:0] held_m;
        repeat (3) @(negedge clk);
        check("R1 reset target", 128'(pred_target), 128'(0));
        check("R1 reset meta", 128'(pred_meta), 128'(0));
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            string ttag;
            @(negedge clk);
            drive(VECS[k], 1'b1);
            @(negedge clk);
            s2_fire = 1'b0;
            if (VECS[k].sel == 0 && VECS[k].prov == 0) ttag = "R2 target";
            else if (VECS[k].sel == 0) ttag = "R5 target";
            else if (VECS[k].sel == VECS[k].prov) ttag = "R3 target";
            else ttag = "R4 target";
            check(ttag, 128'(pred_target),
                  128'((VECS[k].sel == 0) ? fallback_target : tgt(int'(VECS[k].sel))));
            check("R7 R8 R9 R10 meta", 128'(pred_meta), 128'(exp_meta(VECS[k])));
        end

        // R6: stage idle, inputs change, outputs must hold
        held_t = pred_target;
        held_m = pred_meta;
        @(negedge clk);
        drive(VECS[4], 1'b0);
        fallback_target = 41'h1F0_0F0F_0F0F;
        repeat (3) @(negedge clk);
        check("R6 hold target", 128'(pred_target), 128'(held_t));
        check("R6 hold meta", 128'(pred_meta), 128'(held_m));

        // R11: new lookup invisible before the edge, visible just after
        drive(VECS[0], 1'b1);
        #1;
        check("R11 before edge", 128'(pred_target), 128'(held_t));
        @(posedge clk);
        #1;
        s2_fire = 1'b0;
        check("R11 after edge", 128'(pred_target), 128'(41'h1F0_0F0F_0F0F));
        check("R11 meta after edge", 128'(pred_meta), 128'(exp_meta(VECS[0])));

        // R1: reset mid-run clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset target", 128'(pred_target), 128'(0));
        check("R1 mid-run reset meta", 128'(pred_meta), 128'(0));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule